// File: doc/BRIEF.md
# Delayed Sweep Start Controller

This block decides when a second, delayed ramp may run. A digital compare input reports that the main ramp has passed a delay set-point. When that input rises, an arm latch sets. In free-run mode the delayed ramp is released at once. In triggered mode the ramp is released by the first trigger event that follows arming, and any later triggers are ignored.

The arm latch clears, and the delayed ramp goes back to reset, in two cases: during the holdoff interval, and on a falling edge of the main-sweep sync line. The sync edge acts even when the delayed ramp has not finished. A sweep-end flag blanks the trace while the ramp keeps running. After any reset, a new delayed sweep needs a fresh rising crossing of the compare input.

The compare, trigger, sync and sweep-end inputs are asynchronous. Each passes through a two-flop synchronizer, and edges are detected on the synchronized copies. The strobe enable, the holdoff input and the mode select are synchronous levels.

Top module: `dly_sweep_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block enters the held state: ramp_hold=1 and blank=1.
- R2: While strobe_en is 0, a rising edge of cmp_async is ignored and the ramp stays held. Raising strobe_en while cmp_async is already high does not count as a crossing.
- R3: While holdoff is 1, the arm latch is cleared and ramp_hold=1, whatever the other inputs do.
- R4: With run_mode=1, a qualified rising edge of cmp_async releases the ramp (ramp_hold=0) with no trigger. An input change shows at the outputs after at most 3 clock edges.
- R5: With run_mode=0, a qualified compare rise arms the block but the ramp stays held. The first rising edge of trig_async after arming releases it.
- R6: While the ramp is released, further trigger edges have no effect and ramp_hold stays 0.
- R7: A falling edge of alt_sync_async clears the arm latch and sets ramp_hold=1. This applies in both the armed state and the running state.
- R8: While the ramp is released, sweep_end_async=1 makes blank=1 and leaves ramp_hold=0. When it returns to 0, blank returns to 0.
- R9: After any reset of the ramp, a compare input that stays high does not re-arm the block. Only a new rising edge does.
- R10: blank is 1 whenever ramp_hold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_mode | input | 1 | 1 = free start at the delay, 0 = wait for a trigger after the delay |
| strobe_en | input | 1 | Enables the compare input |
| holdoff | input | 1 | Holdoff interval; clears the arm latch |
| cmp_async | input | 1 | Main ramp is above the delay set-point (asynchronous) |
| trig_async | input | 1 | Trigger event; the rising edge counts (asynchronous) |
| alt_sync_async | input | 1 | Main-sweep sync; the falling edge forces reset (asynchronous) |
| sweep_end_async | input | 1 | Delayed ramp has reached its end (asynchronous) |
| ramp_hold | output | 1 | 1 = delayed ramp held in reset |
| blank | output | 1 | 1 = trace blanked |

## Verification
The release path is tested in both modes. In free-run mode a compare rise alone must release the ramp. In triggered mode the same rise must not release it until a trigger arrives, which shows whether the mode select is actually decoded. Compare rises are also applied with the strobe low, and with the compare held high across a sync-edge reset, to separate a true crossing from a level. The clearing paths (sync falling edge and holdoff) are applied both while armed and while running, so that each is shown to clear the latch itself and not only to stop a sweep that is already running.

// File: rtl/dly_sweep_pkg.sv
// Package: shared state encoding and input bit positions for the
// delayed sweep start controller. Assumes nothing beyond IEEE 1800-2017.
package dly_sweep_pkg;

    // Bit positions of the asynchronous inputs inside the sync vector
    localparam int unsigned IDX_CMP  = 0;
    localparam int unsigned IDX_TRIG = 1;
    localparam int unsigned IDX_ALT  = 2;
    localparam int unsigned IDX_END  = 3;
    localparam int unsigned N_ASYNC  = 4;

    // Ramp control states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // latch clear, ramp held
        ST_ARMED = 2'd1,   // latch set, waiting for a trigger
        ST_RUN   = 2'd2    // ramp released
    } ramp_st_e;

endpackage

// File: rtl/dly_sweep_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit, all reset to 0.
// Assumes every bit is an independent level; no bus coherence is given.
module dly_sweep_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift each bit one stage further into the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_async;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];

endmodule

// File: rtl/dly_sweep_edge.sv
// Edge detector: registers the previous value of each bit and gives
// single-cycle rise and fall pulses. Assumes inputs are already synchronous.
module dly_sweep_edge #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] prev;

    // Purpose: remember the last sampled level of every bit
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = lvl[b] & ~prev[b];
            assign fall[b] = ~lvl[b] & prev[b];
        end
    endgenerate

endmodule

// File: rtl/dly_sweep_fsm.sv
// Arm/run state machine for the delayed ramp. Clearing events (holdoff,
// sync fall) take priority over starting events in the same cycle.
// Assumes all event inputs are single-cycle synchronous pulses.
module dly_sweep_fsm
    import dly_sweep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_mode,
    input  logic arm_evt,
    input  logic trig_evt,
    input  logic clr_evt,
    input  logic end_lvl,
    output logic ramp_hold,
    output logic blank,
    output logic armed
);
    ramp_st_e st_q, st_nx;

    // Purpose: hold the current ramp control state
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Purpose: choose the next state; clearing wins over starting
    always_comb begin
        st_nx = st_q;
        if (clr_evt) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (arm_evt)  st_nx = run_mode ? ST_RUN : ST_ARMED;
                ST_ARMED: if (trig_evt) st_nx = ST_RUN;
                ST_RUN:   st_nx = ST_RUN;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    assign ramp_hold = (st_q != ST_RUN);
    assign armed     = (st_q == ST_ARMED);
    assign blank     = ramp_hold | end_lvl;

endmodule

// File: rtl/dly_sweep_ctrl.sv
// Top: delayed sweep start controller. Synchronizes the asynchronous
// inputs, finds their edges, gates the compare edge with the strobe and
// drives the arm/run state machine. Assumes strobe_en, holdoff and run_mode
// are synchronous to clk.
module dly_sweep_ctrl
    import dly_sweep_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_mode,
    input  logic strobe_en,
    input  logic holdoff,
    input  logic cmp_async,
    input  logic trig_async,
    input  logic alt_sync_async,
    input  logic sweep_end_async,
    output logic ramp_hold,
    output logic blank
);
    logic [N_ASYNC-1:0] raw_in, lvl_s, rise_s, fall_s;
    logic cmp_rise, trig_rise, alt_fall, clr_evt, armed;

    assign raw_in[IDX_CMP]  = cmp_async;
    assign raw_in[IDX_TRIG] = trig_async;
    assign raw_in[IDX_ALT]  = alt_sync_async;
    assign raw_in[IDX_END]  = sweep_end_async;

    dly_sweep_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(raw_in), .q_sync(lvl_s)
    );

    dly_sweep_edge #(.WIDTH(N_ASYNC)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_s), .rise(rise_s), .fall(fall_s)
    );

    // A compare edge counts only while the strobe enables the comparator
    assign cmp_rise  = rise_s[IDX_CMP] & strobe_en;
    assign trig_rise = rise_s[IDX_TRIG];
    assign alt_fall  = fall_s[IDX_ALT];
    assign clr_evt   = alt_fall | holdoff;

    dly_sweep_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
        .arm_evt(cmp_rise), .trig_evt(trig_rise), .clr_evt(clr_evt),
        .end_lvl(lvl_s[IDX_END]),
        .ramp_hold(ramp_hold), .blank(blank), .armed(armed)
    );

endmodule

// File: rtl/dly_sweep_ctrl_chk.sv
// Checker: temporal properties of the delayed sweep start controller,
// bound to the top. Assumes the top's internal event names are visible.
module dly_sweep_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic run_mode,
    input logic strobe_en,
    input logic holdoff,
    input logic cmp_rise,
    input logic alt_fall,
    input logic armed,
    input logic ramp_hold,
    input logic blank
);
    AST_RESET_HELD: assert property (@(posedge clk) !rst_n |=> (ramp_hold && blank)); // R1

    AST_STROBE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_hold && !armed && !strobe_en) |=> ramp_hold); // R2

    AST_HOLDOFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        holdoff |=> (ramp_hold && !armed)); // R3

    AST_FREE_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ramp_hold) && $past(run_mode)) |-> ($past(cmp_rise) || $past(armed))); // R4

    AST_TRIG_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ramp_hold) && !$past(run_mode)) |-> $past(armed)); // R5

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_hold && !alt_fall && !holdoff) |=> !ramp_hold); // R6

    AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        alt_fall |=> (ramp_hold && !armed)); // R7

    AST_BLANK_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_hold |-> blank); // R10

endmodule

bind dly_sweep_ctrl dly_sweep_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .strobe_en(strobe_en),
    .holdoff(holdoff), .cmp_rise(cmp_rise), .alt_fall(alt_fall),
    .armed(armed), .ramp_hold(ramp_hold), .blank(blank)
);

// File: tb/dly_sweep_ctrl_tb_top.sv
// Scoreboard bench: the driver applies a stimulus, waits for it to settle
// and queues the expected outputs; the monitor pops and compares at negedge.
module dly_sweep_ctrl_tb_top;

    typedef struct {
        logic  hold;
        logic  blnk;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_mode = 1'b1, strobe_en = 1'b0, holdoff = 1'b0;
    logic cmp_async = 1'b0, trig_async = 1'b0, alt_sync_async = 1'b1, sweep_end_async = 1'b0;
    logic ramp_hold, blank;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dly_sweep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .run_mode(run_mode), .strobe_en(strobe_en),
        .holdoff(holdoff), .cmp_async(cmp_async), .trig_async(trig_async),
        .alt_sync_async(alt_sync_async), .sweep_end_async(sweep_end_async),
        .ramp_hold(ramp_hold), .blank(blank)
    );

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Queue an expectation, then wait until the monitor has consumed it
    task automatic expect_out(input logic h, input logic b, input string tag);
        exp_t e;
        e.hold = h; e.blnk = b; e.tag = tag;
        exp_q.push_back(e);
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic pulse_trig();
        trig_async = 1'b1; settle(3);
        trig_async = 1'b0; settle(6);
    endtask

    // Monitor: compare outputs against the oldest expectation
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (ramp_hold !== e.hold || blank !== e.blnk) begin
                    n_fail++;
                    $display("FAIL %s: hold=%b blank=%b expected hold=%b blank=%b",
                             e.tag, ramp_hold, blank, e.hold, e.blnk);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        settle(4);
        expect_out(1'b1, 1'b1, "R1 reset held and blanked");
        rst_n = 1'b1; settle(6);
        expect_out(1'b1, 1'b1, "R10 idle after reset blanked");

        // Strobe low: compare edge ignored
        cmp_async = 1'b1; settle(6);
        expect_out(1'b1, 1'b1, "R2 compare ignored with strobe low");
        strobe_en = 1'b1; settle(6);
        expect_out(1'b1, 1'b1, "R2 strobe rise is not a crossing");
        cmp_async = 1'b0; settle(6);

        // Free-run start
        cmp_async = 1'b1; settle(6);
        expect_out(1'b0, 1'b0, "R4 free start on compare rise");
        sweep_end_async = 1'b1; settle(6);
        expect_out(1'b0, 1'b1, "R8 sweep end blanks, ramp still released");
        sweep_end_async = 1'b0; settle(6);
        expect_out(1'b0, 1'b0, "R8 blank clears after sweep end");
        pulse_trig();
        expect_out(1'b0, 1'b0, "R6 trigger ignored while running");

        // Sync fall with compare still high
        alt_sync_async = 1'b0; settle(6);
        expect_out(1'b1, 1'b1, "R7 sync fall resets running ramp");
        alt_sync_async = 1'b1; settle(8);
        expect_out(1'b1, 1'b1, "R9 steady compare does not re-arm");
        cmp_async = 1'b0; settle(6);
        cmp_async = 1'b1; settle(6);
        expect_out(1'b0, 1'b0, "R9 new crossing restarts");

        // Holdoff clears
        holdoff = 1'b1; settle(2);
        expect_out(1'b1, 1'b1, "R3 holdoff holds ramp");
        holdoff = 1'b0; settle(6);
        expect_out(1'b1, 1'b1, "R3 stays held after holdoff");

        // Triggered mode
        run_mode = 1'b0;
        cmp_async = 1'b0; settle(6);
        cmp_async = 1'b1; settle(6);
        expect_out(1'b1, 1'b1, "R5 armed but held without trigger");
        pulse_trig();
        expect_out(1'b0, 1'b0, "R5 first trigger releases ramp");
        pulse_trig();
        expect_out(1'b0, 1'b0, "R6 later trigger has no effect");

        // Sync fall while armed
        alt_sync_async = 1'b0; settle(6);
        alt_sync_async = 1'b1;
        cmp_async = 1'b0; settle(6);
        cmp_async = 1'b1; settle(6);
        expect_out(1'b1, 1'b1, "R5 re-armed and held");
        alt_sync_async = 1'b0; settle(6);
        pulse_trig();
        expect_out(1'b1, 1'b1, "R7 sync fall clears arm latch");

        // Holdoff while armed
        alt_sync_async = 1'b1;
        cmp_async = 1'b0; settle(6);
        cmp_async = 1'b1; settle(6);
        holdoff = 1'b1; settle(2);
        holdoff = 1'b0; settle(2);
        pulse_trig();
        expect_out(1'b1, 1'b1, "R3 holdoff clears arm latch");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule